// File: doc/BRIEF.md
# Burst Read Memory Slave

This block answers read bursts on an AXI4 read address and read data channel pair from a preloaded internal memory. Requests are captured on the address channel whenever the slave is ready. They wait in a small in-order queue, and a two-state beat engine expands each one into its sequence of beat addresses. For every beat the engine fetches one full bus-width word and places it on the read data channel together with the request tag, an OKAY response and a final-beat marker.

The engine has two states. `ST_IDLE` waits for the queue. Its transition *take* fires when the queue is not empty: it pops the head request, loads the aligned start address, the wrap window and the remaining-beat count, and moves to `ST_STREAM`. In `ST_STREAM`, each free output slot moves the current beat into the output register. Its transition *advance* steps to the next beat address when beats remain. Its transition *finish* returns to `ST_IDLE` after the final beat is loaded. Reset forces `ST_IDLE` from either state.

Narrow transfers are not lane-masked: each beat always carries the whole word that contains its address. The memory is read-only. At reset it is filled with a fixed arithmetic pattern, so that contents are known without a write path.

Top module: `axi_read_mem_slave`

## Requirements
- R1: Outside reset, arready is high whenever the request queue is not full, and a request is captured on every cycle where arvalid and arready are both high.
- R2: The queue holds QDEPTH requests. While the engine is stalled inside a burst, at most QDEPTH+1 requests are accepted, and after that arready stays low.
- R3: Bursts are returned strictly in the order their requests were accepted, with no interleaving of beats.
- R4: A burst has arlen+1 beats of 2^arsize bytes each. The first beat address is araddr rounded down to 2^arsize. Burst type 0 (fixed) repeats that address. Type 1 (incrementing) adds 2^arsize per beat. Type 2 (wrapping) also increments, but returns to the bottom of the aligned window of 2^arsize*(arlen+1) bytes that contains araddr when it reaches the top of that window.
- R5: Beat data is the whole DATA_W word at the beat address rounded down to DATA_W/8 bytes, taken modulo MEM_BYTES. It is assembled little-endian (lowest address in bits 7:0). After reset, the byte at address a holds (37*a + 11) mod 256.
- R6: Every beat carries rid equal to the request's arid and rresp = 2'b00 (OKAY). rlast is 1 only on beat arlen+1.
- R7: While rvalid is high and rready is low, rvalid, rdata, rid and rlast hold their values into the next cycle.
- R8: While reset is high, arready is low. One clock edge into reset, rvalid, rid, rdata, rresp and rlast are zero. Requests pending at reset are discarded.
- R9: When the block is idle, the first beat of an accepted request is valid two clock edges after the acceptance edge. With rready held high, the following beats come on consecutive cycles.
- R10: The value on arprot has no effect on any returned beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_arid | input | ID_W | Request tag |
| s_araddr | input | ADDR_W | Byte start address |
| s_arlen | input | 8 | Beats minus one |
| s_arsize | input | 3 | log2 of bytes per beat |
| s_arburst | input | 2 | 0 fixed, 1 incrementing, 2 wrapping |
| s_arprot | input | 3 | Protection attributes, ignored |
| s_arvalid | input | 1 | Request valid |
| s_arready | output | 1 | Request accepted when high with arvalid |
| s_rid | output | ID_W | Tag of the returned beat |
| s_rdata | output | DATA_W | Beat data word |
| s_rresp | output | 2 | Response, always OKAY |
| s_rlast | output | 1 | Final beat of the burst |
| s_rvalid | output | 1 | Beat valid |
| s_rready | input | 1 | Master accepts the beat |

## Verification
Acceptance is combinational with the queue state, so arready is sampled on the same falling edge at which arvalid is driven. The first beat of a lone request is due two rising edges after its acceptance edge: one edge for the engine's *take* and one to load the output register. The latency test samples rvalid on the falling edges after each of those edges. All other beats are gathered only on falling edges where rvalid and rready are both high, so that bursts stalled by backpressure are compared beat by beat against addresses and bytes computed arithmetically from the requirements. On stalled cycles the held word is compared with the previous falling edge, and the reset checks sample one falling edge after the first reset edge.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

    typedef enum logic [1:0] {
        BT_FIXED = 2'd0,
        BT_INCR  = 2'd1,
        BT_WRAP  = 2'd2,
        BT_RSVD  = 2'd3
    } burst_e;

    typedef enum logic {
        ST_IDLE,
        ST_STREAM
    } eng_state_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/rdm_req_queue.sv
module rdm_req_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slots_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign dout  = slots_q[rd_q];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                slots_q[wr_q] <= din;
                wr_q          <= bump(wr_q);
            end
            if (pop) begin
                rd_q <= bump(rd_q);
            end
            if (push && !pop) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (pop && !push) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/rdm_word_store.sv
module rdm_word_store #(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 256
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(MEM_WORDS)-1:0] rd_idx,
    output logic [DATA_W-1:0]            rd_word
);
    localparam int BYTES = DATA_W / 8;

    logic [DATA_W-1:0] words_q [MEM_WORDS];

    // Preload: byte at address a holds 37*a + 11 (mod 256), little-endian lanes.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < MEM_WORDS; w++) begin
                for (int j = 0; j < BYTES; j++) begin
                    words_q[w][8*j +: 8] <= 8'(((w * BYTES + j) * 37) + 11);
                end
            end
        end
    end

    assign rd_word = words_q[rd_idx];

endmodule

// File: rtl/rdm_beat_engine.sv
module rdm_beat_engine
    import rdm_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 256
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_avail,
    output logic                         req_take,
    input  logic [ID_W-1:0]              req_id,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [7:0]                   req_len,
    input  logic [2:0]                   req_size,
    input  logic [1:0]                   req_burst,
    output logic [$clog2(MEM_WORDS)-1:0] mem_idx,
    input  logic [DATA_W-1:0]            mem_word,
    output logic [ID_W-1:0]              r_id,
    output logic [DATA_W-1:0]            r_data,
    output logic [1:0]                   r_resp,
    output logic                         r_last,
    output logic                         r_valid,
    input  logic                         r_ready
);
    localparam int LANE_LG = $clog2(DATA_W / 8);
    localparam int IDX_W   = $clog2(MEM_WORDS);

    eng_state_e        state_q;
    logic [ADDR_W-1:0] cur_q, lo_q, hi_q, step_q;
    burst_e            burst_q;
    logic [7:0]        left_q;
    logic [ID_W-1:0]   id_q;

    logic [ADDR_W-1:0] ld_step, ld_span, ld_lo, ld_start;
    logic [ADDR_W-1:0] sum, nxt;
    logic              slot_free;

    assign slot_free = !r_valid || r_ready;
    assign req_take  = (state_q == ST_IDLE) && req_avail;
    assign mem_idx   = cur_q[LANE_LG +: IDX_W];

    always_comb begin
        ld_step  = ADDR_W'(1) << req_size;
        ld_span  = ld_step * (ADDR_W'(req_len) + ADDR_W'(1));
        ld_lo    = req_addr & ~(ld_span - ADDR_W'(1));
        ld_start = req_addr & ~(ld_step - ADDR_W'(1));
        sum      = cur_q + step_q;
        if (burst_q == BT_FIXED) begin
            nxt = cur_q;
        end else if (burst_q == BT_WRAP && sum == hi_q) begin
            nxt = lo_q;
        end else begin
            nxt = sum;
        end
    end

    // State and beat-address register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            step_q  <= '0;
            burst_q <= BT_FIXED;
            left_q  <= '0;
            id_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_avail) begin
                        cur_q   <= ld_start;
                        lo_q    <= ld_lo;
                        hi_q    <= ld_lo + ld_span;
                        step_q  <= ld_step;
                        burst_q <= burst_e'(req_burst);
                        left_q  <= req_len;
                        id_q    <= req_id;
                        state_q <= ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (slot_free) begin
                        if (left_q == 8'd0) begin
                            state_q <= ST_IDLE;
                        end else begin
                            left_q <= left_q - 8'd1;
                            cur_q  <= nxt;
                        end
                    end
                end
            endcase
        end
    end

    // Output register of the read data channel
    always_ff @(posedge clk) begin
        if (rst) begin
            r_valid <= 1'b0;
            r_id    <= '0;
            r_data  <= '0;
            r_resp  <= '0;
            r_last  <= 1'b0;
        end else if (slot_free) begin
            if (state_q == ST_STREAM) begin
                r_valid <= 1'b1;
                r_id    <= id_q;
                r_data  <= mem_word;
                r_resp  <= RESP_OKAY;
                r_last  <= (left_q == 8'd0);
            end else begin
                r_valid <= 1'b0;
            end
        end
    end

    assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_id) && $stable(r_last)));

    assert_wrap_window_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STREAM && burst_q == BT_WRAP) |-> (cur_q >= lo_q && cur_q < hi_q));

endmodule

// File: rtl/axi_read_mem_slave.sv
module axi_read_mem_slave #(
    parameter int ID_W      = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int MEM_BYTES = 1024,
    parameter int QDEPTH    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   s_arid,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic [7:0]        s_arlen,
    input  logic [2:0]        s_arsize,
    input  logic [1:0]        s_arburst,
    input  logic [2:0]        s_arprot,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [ID_W-1:0]   s_rid,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rlast,
    output logic              s_rvalid,
    input  logic              s_rready
);
    localparam int MEM_WORDS = MEM_BYTES / (DATA_W / 8);
    localparam int IDX_W     = $clog2(MEM_WORDS);
    localparam int REQ_W     = ID_W + ADDR_W + 8 + 3 + 2;

    logic             q_full, q_empty, q_push, q_pop;
    logic [REQ_W-1:0] q_din, q_dout;
    logic [ID_W-1:0]  h_id;
    logic [ADDR_W-1:0] h_addr;
    logic [7:0]       h_len;
    logic [2:0]       h_size;
    logic [1:0]       h_burst;
    logic [IDX_W-1:0] m_idx;
    logic [DATA_W-1:0] m_word;
    logic             prot_unused;

    assign prot_unused = ^s_arprot;
    assign s_arready   = !rst && !q_full;
    assign q_push      = s_arvalid && s_arready;
    assign q_din       = {s_arid, s_araddr, s_arlen, s_arsize, s_arburst};
    assign {h_id, h_addr, h_len, h_size, h_burst} = q_dout;

    rdm_req_queue #(.W(REQ_W), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst(rst),
        .push(q_push), .din(q_din), .full(q_full),
        .pop(q_pop), .dout(q_dout), .empty(q_empty)
    );

    rdm_word_store #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) u_store (
        .clk(clk), .rst(rst), .rd_idx(m_idx), .rd_word(m_word)
    );

    rdm_beat_engine #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)
    ) u_engine (
        .clk(clk), .rst(rst),
        .req_avail(!q_empty), .req_take(q_pop),
        .req_id(h_id), .req_addr(h_addr), .req_len(h_len),
        .req_size(h_size), .req_burst(h_burst),
        .mem_idx(m_idx), .mem_word(m_word),
        .r_id(s_rid), .r_data(s_rdata), .r_resp(s_rresp),
        .r_last(s_rlast), .r_valid(s_rvalid), .r_ready(s_rready)
    );

    assert_reset_quiet_R8: assert property (@(posedge clk)
        rst |=> (!s_rvalid && !s_rlast && s_rdata == '0));

    assert_ready_low_in_reset_R8: assert property (@(posedge clk)
        rst |-> !s_arready);

    assert_accept_when_room_R1: assert property (@(posedge clk) disable iff (rst)
        !q_full |-> s_arready);

endmodule

// File: tb/test_axi_read_mem_slave.sv
module test_axi_read_mem_slave;
    localparam int ID_W = 4, ADDR_W = 16, DATA_W = 32, MEM_BYTES = 1024, QDEPTH = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ID_W-1:0]   ar_id = '0;
    logic [ADDR_W-1:0] ar_addr = '0;
    logic [7:0]        ar_len = '0;
    logic [2:0]        ar_size = '0;
    logic [1:0]        ar_burst = '0;
    logic [2:0]        ar_prot = '0;
    logic              ar_valid = 1'b0;
    logic              ar_ready;
    logic [ID_W-1:0]   r_id;
    logic [DATA_W-1:0] r_data;
    logic [1:0]        r_resp;
    logic              r_last;
    logic              r_valid;
    logic              r_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    axi_read_mem_slave #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                         .MEM_BYTES(MEM_BYTES), .QDEPTH(QDEPTH)) i_axi_read_mem_slave (
        .clk(clk), .rst(rst),
        .s_arid(ar_id), .s_araddr(ar_addr), .s_arlen(ar_len), .s_arsize(ar_size),
        .s_arburst(ar_burst), .s_arprot(ar_prot), .s_arvalid(ar_valid), .s_arready(ar_ready),
        .s_rid(r_id), .s_rdata(r_data), .s_rresp(r_resp), .s_rlast(r_last),
        .s_rvalid(r_valid), .s_rready(r_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int pat(input int a);
        return ((a % MEM_BYTES) * 37 + 11) % 256;
    endfunction

    function automatic logic [31:0] exp_word(input int beat);
        int base = beat & ~3;
        return {8'(pat(base + 3)), 8'(pat(base + 2)), 8'(pat(base + 1)), 8'(pat(base))};
    endfunction

    function automatic int beat_addr(input int addr, input int len, input int size,
                                     input int burst, input int n);
        int nb   = 1 << size;
        int span = nb * (len + 1);
        int lo   = (addr / span) * span;
        int cur  = (addr / nb) * nb;
        for (int k = 0; k < n; k++) begin
            if (burst != 0) begin
                cur = cur + nb;
                if (burst == 2 && cur == lo + span) cur = lo;
            end
        end
        return cur & 16'hFFFF;
    endfunction

    task automatic send_ar(input int id, input int addr, input int len, input int size,
                           input int burst, input int prot);
        bit done = 0;
        @(negedge clk);
        ar_id = ID_W'(id); ar_addr = ADDR_W'(addr); ar_len = 8'(len);
        ar_size = 3'(size); ar_burst = 2'(burst); ar_prot = 3'(prot); ar_valid = 1'b1;
        while (!done) begin
            if (ar_ready) begin
                @(posedge clk);
                done = 1;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        ar_valid = 1'b0;
    endtask

    task automatic collect(input int id, input int addr, input int len, input int size,
                           input int burst, input bit bp);
        for (int n = 0; n <= len; n++) begin
            bit got = 0;
            bit stalled = 0;
            logic [DATA_W-1:0] held = '0;
            while (!got) begin
                @(negedge clk);
                r_ready = bp ? ((cyc % 3) != 0) : 1'b1;
                if (r_valid && stalled) begin
                    chk(r_data == held, "R7", "held data", r_data, held);
                end
                if (r_valid && r_ready) begin
                    logic [31:0] ew = exp_word(beat_addr(addr, len, size, burst, n));
                    chk(r_data == ew, "R5", "beat data", r_data, ew);
                    chk(r_id == ID_W'(id), "R6", "rid", r_id, id);
                    chk(r_resp == 2'b00, "R6", "rresp", r_resp, 0);
                    chk(r_last == (n == len), "R6", "rlast", r_last, (n == len));
                    got = 1;
                end else if (r_valid) begin
                    stalled = 1;
                    held = r_data;
                end
            end
        end
        @(negedge clk);
        r_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int lens[5] = '{0, 1, 3, 7, 15};
        int addrs[5] = '{16'h0000, 16'h0013, 16'h03FE, 16'h07F5, 16'h1234};
        int acc;
        int nid = 0;

        // R8: state in reset
        repeat (2) @(negedge clk);
        chk(ar_ready == 1'b0, "R8", "arready in reset", ar_ready, 0);
        chk(r_valid == 1'b0, "R8", "rvalid in reset", r_valid, 0);
        chk(r_data == '0 && r_id == '0 && r_last == 1'b0 && r_resp == 2'b00,
            "R8", "outputs zero", r_data, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ar_ready == 1'b1, "R1", "arready after reset", ar_ready, 1);

        // R9: latency of the first beat and back-to-back beats
        r_ready = 1'b1;
        ar_id = 4'd9; ar_addr = 16'h0040; ar_len = 8'd3; ar_size = 3'd2;
        ar_burst = 2'd1; ar_prot = 3'd0; ar_valid = 1'b1;
        chk(ar_ready == 1'b1, "R1", "arready idle", ar_ready, 1);
        @(posedge clk);
        @(negedge clk);
        ar_valid = 1'b0;
        chk(r_valid == 1'b0, "R9", "rvalid one edge after accept", r_valid, 0);
        @(negedge clk);
        chk(r_valid == 1'b0, "R9", "rvalid after take", r_valid, 0);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk(r_valid == 1'b1, "R9", "rvalid streaming", r_valid, 1);
            chk(r_data == exp_word(16'h0040 + 4 * n), "R9", "data streaming",
                r_data, exp_word(16'h0040 + 4 * n));
        end
        @(negedge clk);
        r_ready = 1'b0;

        // R4 R5 R6 R7 R10: sweep of burst types, sizes, lengths and addresses
        for (int s = 0; s < 3; s++) begin
            for (int b = 0; b < 3; b++) begin
                for (int li = 0; li < 5; li++) begin
                    for (int ai = 0; ai < 5; ai++) begin
                        if (!(b == 2 && lens[li] == 0)) begin
                            send_ar(nid % 16, addrs[ai], lens[li], s, b, nid % 8);
                            collect(nid % 16, addrs[ai], lens[li], s, b, (nid % 2) == 1);
                            nid++;
                        end
                    end
                end
            end
        end

        // R10: same request with two protection values
        for (int p = 0; p < 8; p += 7) begin
            send_ar(3, 16'h0105, 3, 1, 2, p);
            collect(3, 16'h0105, 3, 1, 2, 1'b0);
        end

        // R2: fill the queue while the engine is stalled
        r_ready = 1'b0;
        acc = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ar_id = ID_W'(acc); ar_addr = ADDR_W'(acc * 16); ar_len = 8'd1;
            ar_size = 3'd2; ar_burst = 2'd1; ar_valid = 1'b1;
            if (ar_ready) begin
                @(posedge clk);
                acc++;
            end
        end
        @(negedge clk);
        ar_valid = 1'b0;
        chk(acc == QDEPTH + 1, "R2", "accepted while stalled", acc, QDEPTH + 1);
        chk(ar_ready == 1'b0, "R2", "arready when full", ar_ready, 0);
        // R3: drained in acceptance order
        for (int k = 0; k < acc; k++) begin
            collect(k, k * 16, 1, 2, 1, 1'b1);
        end

        // R3: requests queued while an earlier burst streams
        fork
            begin
                send_ar(5, 16'h0200, 7, 2, 1, 0);
                send_ar(6, 16'h0031, 3, 0, 2, 0);
                send_ar(7, 16'h0300, 2, 2, 0, 0);
            end
            begin
                collect(5, 16'h0200, 7, 2, 1, 1'b1);
                collect(6, 16'h0031, 3, 0, 2, 1'b0);
                collect(7, 16'h0300, 2, 2, 0, 1'b1);
            end
        join

        // R8: reset in the middle of a burst with a request pending
        r_ready = 1'b0;
        send_ar(1, 16'h0080, 3, 2, 1, 0);
        send_ar(2, 16'h0090, 3, 2, 1, 0);
        @(negedge clk);
        chk(r_valid == 1'b1, "R7", "stalled beat present", r_valid, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(ar_ready == 1'b0, "R8", "arready mid reset", ar_ready, 0);
        chk(r_valid == 1'b0, "R8", "rvalid mid reset", r_valid, 0);
        chk(r_id == '0 && r_last == 1'b0, "R8", "rid/rlast mid reset", r_id, 0);
        rst = 1'b0;
        r_ready = 1'b1;
        acc = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (r_valid) acc++;
        end
        chk(acc == 0, "R8", "beats after reset", acc, 0);
        r_ready = 1'b0;
        send_ar(4, 16'h00A0, 1, 2, 1, 0);
        collect(4, 16'h00A0, 1, 2, 1, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule